// File: doc/BRIEF.md
# DDR Read Burst Command Sequencer

This block drives the command pins of a DDR memory for read traffic to rows that are already open. Each request names a bank, a starting column, how many column pairs the caller wants, an auto-precharge flag and a stop method. The block issues the Read command. It then holds the command bus quiet until the slot that lies x cycles after the Read, where x is the effective pair count. In that slot it places whatever ends the burst early. That can be a burst-terminate, a precharge of the same bank, or a following Read that is waiting. A following Read chains the two bursts with no gap on the data bus.

Alongside the command path, the block follows the data bus. For each burst it marks the cycles in which data is driven, the strobe preamble cycle and the strobe postamble cycle. It uses the same record to hold back a Write until no read data is pending or in flight.

Top module: `rd_burst_seq`

## Requirements
- R1: After reset, the command pins show NOP: chip select, row strobe, column strobe and write enable are 0, 1, 1 and 1. Clock enable is 1. `req_ready` is 1, and `bus_drive`, `dqs_pre` and `dqs_post` are 0.
- R2: An accepted read request appears on the pins in the next cycle as chip select 0, row strobe 1, column strobe 0 and write enable 1. `cmd_ba` carries the bank. Address bits [COL_W-1:0] carry the column, address bit 10 carries the auto-precharge flag, and every other address bit is 0.
- R3: In the cycles between a Read and its slot the pins show NOP. Over the same interval `req_ready` is 0, so a waiting request is neither taken nor lost. The slot is the cycle x after the Read.
- R4: The effective pair count x is the requested count limited to the range 1 to BL/2. When the stop method is "none" (code 0, or the unused code 3), x is BL/2.
- R5: With stop method "terminate" (code 1), and no read waiting at the slot, a burst-terminate appears exactly x cycles after the Read. Its encoding is chip select 0, row strobe 1, column strobe 1 and write enable 0.
- R6: With stop method "precharge" (code 2), and no read waiting at the slot, a precharge appears exactly x cycles after the Read. Its encoding is chip select 0, row strobe 0, column strobe 1 and write enable 0, with the Read's bank and address bit 10 at 0.
- R7: A read request waiting in the slot cycle is issued in the slot, and the earlier burst's own stop command is dropped. The data bus stays driven without a gap, and there is neither a postamble nor a preamble between the two bursts.
- R8: For a Read shown in cycle t, `bus_drive` is 1 in cycles t+CL to t+CL+x-1.
- R9: `dqs_pre` is 1 in cycle t+CL-1 when the bus was idle before. `dqs_post` is 1 in the burst's last data cycle unless a chained burst follows straight on.
- R10: A write request is taken only when no Read is waiting for its slot, no read data is scheduled and the bus is not driven. It then appears as chip select 0, row strobe 1, column strobe 0 and write enable 0, with the bank, the column and address bit 10 at 0.
- R11: With auto-precharge set, x is BL/2 whatever the requested count, and no terminate or precharge command is issued for that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_bank | input | BA_W | Target bank |
| req_col | input | COL_W | Starting column |
| req_pairs | input | PAIR_W | Wanted column pairs |
| req_ap | input | 1 | Auto-precharge on the read |
| req_stop | input | 2 | 0 none, 1 terminate, 2 precharge, 3 none |
| req_ready | output | 1 | Request is taken at this edge when valid |
| cmd_cke | output | 1 | Clock enable pin |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BA_W | Bank address pins |
| cmd_addr | output | ADDR_W | Address pins |
| bus_drive | output | 1 | Read data on the bus this cycle |
| dqs_pre | output | 1 | Strobe preamble cycle |
| dqs_post | output | 1 | Strobe postamble cycle |

## Verification
Two things can claim the same cycle. In the slot cycle, a chained Read competes with the first burst's terminate or precharge. The bench holds a second read request from the cycle of the first Read onward. It then checks that `req_ready` stays low until the slot, that the second Read lands exactly x cycles after the first, and that no terminate appears there. Where the first burst's last data meets the second burst's first data, the postamble and the preamble would fall together. The bench judges this by requiring `bus_drive` to stay high across the join, with `dqs_post` and `dqs_pre` both low there.

// File: rtl/rdq_pkg.sv
// Shared types for the read burst sequencer.
// Assumes: the command pins are active low, and clock enable is held high by the top.
package rdq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_READ  = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_BST   = 3'd3,
        CMD_PRE   = 3'd4
    } rdq_cmd_e;

    typedef enum logic [1:0] {
        STOP_NONE = 2'd0,
        STOP_BST  = 2'd1,
        STOP_PRE  = 2'd2,
        STOP_RSV  = 2'd3
    } rdq_stop_e;

    // Map a command to {cs_n, ras_n, cas_n, we_n}.
    function automatic logic [3:0] cmd_pins(rdq_cmd_e c);
        case (c)
            CMD_READ:  return 4'b0101;
            CMD_WRITE: return 4'b0100;
            CMD_BST:   return 4'b0110;
            CMD_PRE:   return 4'b0010;
            default:   return 4'b0111;
        endcase
    endfunction

endpackage

// File: rtl/rdq_pair_clamp.sv
// Works out the effective number of column pairs for a read request.
// Assumes: BL is 2, 4 or 8, and PAIR_W is wide enough to hold BL/2.
module rdq_pair_clamp #(
    parameter int BL     = 8,
    parameter int PAIR_W = 3
) (
    input  logic [PAIR_W-1:0] pairs,
    input  logic              ap,
    input  logic [1:0]        stop,
    output logic [PAIR_W-1:0] x_eff
);
    localparam int HALF = BL / 2;

    // Full burst for auto-precharge or no stop; otherwise limit to 1..HALF.
    always_comb begin
        if (ap || stop == rdq_pkg::STOP_NONE || stop == rdq_pkg::STOP_RSV)
            x_eff = PAIR_W'(HALF);
        else if (pairs == '0)
            x_eff = PAIR_W'(1);
        else if (pairs > PAIR_W'(HALF))
            x_eff = PAIR_W'(HALF);
        else
            x_eff = pairs;
    end
endmodule

// File: rtl/rdq_slot_ctrl.sv
// Command timing for read bursts. It issues a Read, counts to the slot
// x cycles later, and there issues a chained Read, a terminate or a precharge.
// Assumes: req_x is already limited to 1..BL/2, and wr_ok reports an idle data bus.
module rdq_slot_ctrl #(
    parameter int BL     = 8,
    parameter int PAIR_W = 3,
    parameter int BA_W   = 2,
    parameter int COL_W  = 9,
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [BA_W-1:0]      req_bank,
    input  logic [COL_W-1:0]     req_col,
    input  logic                 req_ap,
    input  logic [PAIR_W-1:0]    req_x,
    input  logic [1:0]           req_stop,
    input  logic                 wr_ok,
    output logic                 req_ready,
    output logic                 rd_fire,
    output rdq_pkg::rdq_cmd_e    cmd,
    output logic [BA_W-1:0]      cmd_ba,
    output logic [ADDR_W-1:0]    cmd_addr
);
    import rdq_pkg::*;

    localparam int HALF = BL / 2;

    logic              busy;
    logic [PAIR_W-1:0] cnt;
    logic [PAIR_W-1:0] x_cur;
    logic [1:0]        stop_cur;
    logic [BA_W-1:0]   bank_cur;
    logic              slot;
    logic              take;
    logic              wr_fire;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] wr_addr;

    // The slot is the last cycle before the pins show the cycle x after the Read.
    assign slot      = busy && (cnt == x_cur - PAIR_W'(1));
    assign req_ready = req_write ? (!busy && wr_ok) : (!busy || slot);
    assign take      = req_valid && req_ready;
    assign rd_fire   = take && !req_write;
    assign wr_fire   = take && req_write;

    // Build the column addresses: the read carries auto-precharge, the write clears it.
    always_comb begin
        rd_addr                = '0;
        rd_addr[COL_W-1:0]     = req_col;
        rd_addr[AP_BIT]        = req_ap;
        wr_addr                = '0;
        wr_addr[COL_W-1:0]     = req_col;
    end

    // Register the command pins and run the burst slot counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt      <= '0;
            x_cur    <= PAIR_W'(1);
            stop_cur <= STOP_NONE;
            bank_cur <= '0;
            cmd      <= CMD_NOP;
            cmd_ba   <= '0;
            cmd_addr <= '0;
        end else begin
            cmd      <= CMD_NOP;
            cmd_ba   <= '0;
            cmd_addr <= '0;
            if (rd_fire) begin
                cmd      <= CMD_READ;
                cmd_ba   <= req_bank;
                cmd_addr <= rd_addr;
                busy     <= 1'b1;
                cnt      <= '0;
                x_cur    <= req_x;
                stop_cur <= req_stop;
                bank_cur <= req_bank;
            end else if (wr_fire) begin
                cmd      <= CMD_WRITE;
                cmd_ba   <= req_bank;
                cmd_addr <= wr_addr;
            end else if (slot) begin
                busy <= 1'b0;
                if (stop_cur == STOP_BST) begin
                    cmd <= CMD_BST;
                end else if (stop_cur == STOP_PRE) begin
                    cmd    <= CMD_PRE;
                    cmd_ba <= bank_cur;
                end
            end else if (busy) begin
                cnt <= cnt + PAIR_W'(1);
            end
        end
    end

    // R3: between a Read and its slot the pins stay quiet.
    assert_quiet_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !slot) |=> (cmd == CMD_NOP));

    // R3: the counter never passes the slot.
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt < x_cur));

    // R4: a Read only starts with a pair count inside 1..BL/2.
    assert_x_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |-> (req_x >= PAIR_W'(1) && req_x <= PAIR_W'(HALF)));

    // R10: a write is never taken while a burst is counting.
    assert_write_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |-> !busy);
endmodule

// File: rtl/rdq_bus_track.sv
// Follows the read data bus. It delays each Read by CL cycles, then counts
// the data cycles and marks the strobe preamble and postamble.
// Assumes: chained Reads are at least x cycles apart, so bursts never overlap.
module rdq_bus_track #(
    parameter int CL     = 3,
    parameter int BL     = 8,
    parameter int PAIR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PAIR_W-1:0] push_len,
    output logic              bus_drive,
    output logic              dqs_pre,
    output logic              dqs_post,
    output logic              bus_idle
);
    localparam int HALF = BL / 2;

    logic [CL-1:0]     pv;
    logic [PAIR_W-1:0] pl [CL];
    logic [PAIR_W-1:0] dcnt;

    // Latency line: stage j is valid j cycles after the Read shows on the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv <= '0;
            for (int j = 0; j < CL; j++) pl[j] <= '0;
        end else begin
            pv[0] <= push;
            pl[0] <= push_len;
            for (int j = 1; j < CL; j++) begin
                pv[j] <= pv[j-1];
                pl[j] <= pl[j-1];
            end
        end
    end

    // Data counter: load the burst length as the first data cycle begins, then count down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dcnt <= '0;
        else if (pv[CL-1])
            dcnt <= pl[CL-1];
        else if (dcnt != '0)
            dcnt <= dcnt - PAIR_W'(1);
    end

    assign bus_drive = (dcnt != '0);
    assign dqs_pre   = pv[CL-1] && (dcnt == '0);
    assign dqs_post  = (dcnt == PAIR_W'(1)) && !pv[CL-1];
    assign bus_idle  = (pv == '0) && (dcnt == '0);

    // R7: a new burst only reaches the bus as the previous one ends.
    assert_no_collide_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pv[CL-1] |-> (dcnt <= PAIR_W'(1)));

    // R9: a preamble is always followed by driven data.
    assert_pre_then_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_pre |=> bus_drive);

    // R8: a burst never runs longer than BL/2 cycles.
    assert_len_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dcnt <= PAIR_W'(HALF));
endmodule

// File: rtl/rd_burst_seq.sv
// Top of the DDR read burst sequencer. It limits the pair count, times the
// commands in rdq_slot_ctrl, follows the data bus in rdq_bus_track and
// encodes the pins.
// Assumes: rows are already open, BL is 2, 4 or 8, CL >= 1, and COL_W <= AP_BIT.
module rd_burst_seq #(
    parameter int CL     = 3,
    parameter int BL     = 8,
    parameter int PAIR_W = 3,
    parameter int BA_W   = 2,
    parameter int COL_W  = 9,
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic [PAIR_W-1:0] req_pairs,
    input  logic              req_ap,
    input  logic [1:0]        req_stop,
    output logic              req_ready,
    output logic              cmd_cke,
    output logic              cmd_cs_n,
    output logic              cmd_ras_n,
    output logic              cmd_cas_n,
    output logic              cmd_we_n,
    output logic [BA_W-1:0]   cmd_ba,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              bus_drive,
    output logic              dqs_pre,
    output logic              dqs_post
);
    import rdq_pkg::*;

    localparam int HALF = BL / 2;

    logic [PAIR_W-1:0] x_eff;
    logic [1:0]        stop_eff;
    logic              rd_fire;
    logic              bus_idle;
    rdq_cmd_e          cmd;

    // Auto-precharge bursts take no explicit stop command.
    assign stop_eff = req_ap ? STOP_NONE : req_stop;

    rdq_pair_clamp #(.BL(BL), .PAIR_W(PAIR_W)) u_clamp (
        .pairs (req_pairs),
        .ap    (req_ap),
        .stop  (req_stop),
        .x_eff (x_eff)
    );

    rdq_slot_ctrl #(
        .BL(BL), .PAIR_W(PAIR_W), .BA_W(BA_W),
        .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_bank  (req_bank),
        .req_col   (req_col),
        .req_ap    (req_ap),
        .req_x     (x_eff),
        .req_stop  (stop_eff),
        .wr_ok     (bus_idle),
        .req_ready (req_ready),
        .rd_fire   (rd_fire),
        .cmd       (cmd),
        .cmd_ba    (cmd_ba),
        .cmd_addr  (cmd_addr)
    );

    rdq_bus_track #(.CL(CL), .BL(BL), .PAIR_W(PAIR_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rd_fire),
        .push_len  (x_eff),
        .bus_drive (bus_drive),
        .dqs_pre   (dqs_pre),
        .dqs_post  (dqs_post),
        .bus_idle  (bus_idle)
    );

    // Pin encoding; clock enable stays high.
    assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd_pins(cmd);
    assign cmd_cke = 1'b1;

    // R10: a Write on the pins never meets read data or a preamble.
    assert_write_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WRITE) |-> (!bus_drive && !dqs_pre));

    // R11: an accepted auto-precharge read always runs the full burst.
    assert_ap_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && req_ap) |-> (x_eff == PAIR_W'(HALF)));
endmodule

// File: tb/sim_rd_burst_seq.sv
// Self-checking bench: a table of single-read cases, then directed tests for
// reset, chaining and write blocking.
module sim_rd_burst_seq;
    localparam int CL = 3;
    localparam int BL = 8;
    localparam int HALF = BL / 2;
    localparam int PW = 3;
    localparam int CW = 9;
    localparam int AW = 13;
    localparam int NV = 8;
    // columns: pairs, ap, stop, bank, expected x
    localparam int VT [NV][5] = '{
        '{2, 0, 1, 0, 2},
        '{1, 0, 1, 1, 1},
        '{4, 0, 2, 2, 4},
        '{3, 0, 2, 3, 3},
        '{6, 0, 1, 1, 4},
        '{0, 0, 2, 0, 1},
        '{2, 0, 0, 2, 4},
        '{1, 1, 1, 3, 4}
    };
    localparam int C_NOP = 0, C_RD = 1, C_WR = 2, C_BST = 3, C_PRE = 4, C_BAD = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [1:0] req_bank = '0;
    logic [CW-1:0] req_col = '0;
    logic [PW-1:0] req_pairs = '0;
    logic req_ap = 1'b0;
    logic [1:0] req_stop = '0;
    logic req_ready, cmd_cke, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
    logic [1:0] cmd_ba;
    logic [AW-1:0] cmd_addr;
    logic bus_drive, dqs_pre, dqs_post;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rd_burst_seq #(.CL(CL), .BL(BL), .PAIR_W(PW), .COL_W(CW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_col(req_col), .req_pairs(req_pairs),
        .req_ap(req_ap), .req_stop(req_stop), .req_ready(req_ready),
        .cmd_cke(cmd_cke), .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n),
        .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba),
        .cmd_addr(cmd_addr), .bus_drive(bus_drive), .dqs_pre(dqs_pre),
        .dqs_post(dqs_post)
    );

    function automatic int decode();
        case ({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n})
            4'b0111: return C_NOP;
            4'b0101: return C_RD;
            4'b0100: return C_WR;
            4'b0110: return C_BST;
            4'b0010: return C_PRE;
            default: return C_BAD;
        endcase
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic send_read(int bank, int col, int pairs, int ap, int stop);
        req_valid = 1'b1; req_write = 1'b0;
        req_bank = 2'(bank); req_col = CW'(col); req_pairs = PW'(pairs);
        req_ap = ap[0]; req_stop = 2'(stop);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog hang actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cmd", decode(), C_NOP);
        chk("R1", "cke", int'(cmd_cke), 1);
        chk("R1", "ready", int'(req_ready), 1);
        chk("R1", "drive", int'(bus_drive), 0);
        chk("R1", "pre", int'(dqs_pre), 0);
        chk("R1", "post", int'(dqs_post), 0);

        // Table walk: one read from idle per row.
        for (int i = 0; i < NV; i++) begin
            int x;
            int ecmd;
            int col;
            string tg;
            x = VT[i][4];
            col = 16 * i + 5;
            tg = (VT[i][1] != 0) ? "R11" : (VT[i][2] == 2 ? "R6" : (VT[i][2] == 1 ? "R5" : "R4"));
            @(negedge clk);
            send_read(VT[i][3], col, VT[i][0], VT[i][1], VT[i][2]);
            chk("R3", "ready idle", int'(req_ready), 1);
            @(negedge clk);
            req_valid = 1'b0;
            for (int k = 0; k < CL + HALF + 3; k++) begin
                if (k > 0) @(negedge clk);
                if (k == 0) ecmd = C_RD;
                else if (k == x && VT[i][1] == 0 && VT[i][2] == 1) ecmd = C_BST;
                else if (k == x && VT[i][1] == 0 && VT[i][2] == 2) ecmd = C_PRE;
                else ecmd = C_NOP;
                chk(k == 0 ? "R2" : (k == x ? tg : "R3"), "cmd", decode(), ecmd);
                if (k == 0) begin
                    chk("R2", "ba", int'(cmd_ba), VT[i][3]);
                    chk("R2", "addr", int'(cmd_addr), col + (VT[i][1] << 10));
                end
                if (k == x && ecmd == C_PRE) begin
                    chk("R6", "pre ba", int'(cmd_ba), VT[i][3]);
                    chk("R6", "pre a10", int'(cmd_addr[10]), 0);
                end
                chk("R8", "drive", int'(bus_drive), int'(k >= CL && k <= CL + x - 1));
                chk("R9", "pre", int'(dqs_pre), int'(k == CL - 1));
                chk("R9", "post", int'(dqs_post), int'(k == CL + x - 1));
            end
        end

        // R7: chained read held from the first Read's cycle.
        @(negedge clk);
        send_read(1, 7, 2, 0, 1);
        @(negedge clk);
        for (int k = 0; k < 9; k++) begin
            int ecmd;
            if (k > 0) @(negedge clk);
            if (k == 0) begin
                send_read(2, 9, 2, 0, 1);
                chk("R3", "ready held", int'(req_ready), 0);
            end
            if (k == 1) chk("R7", "ready slot", int'(req_ready), 1);
            if (k == 2) begin
                req_valid = 1'b0;
                chk("R7", "ba", int'(cmd_ba), 2);
            end
            ecmd = (k == 0 || k == 2) ? C_RD : (k == 4 ? C_BST : C_NOP);
            chk("R7", "cmd", decode(), ecmd);
            chk("R7", "drive", int'(bus_drive), int'(k >= 3 && k <= 6));
            chk("R7", "pre", int'(dqs_pre), int'(k == 2));
            chk("R7", "post", int'(dqs_post), int'(k == 6));
        end

        // R10: write held behind a terminated read.
        @(negedge clk);
        send_read(0, 3, 2, 0, 1);
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            int ecmd;
            if (k > 0) @(negedge clk);
            if (k == 0) begin
                req_valid = 1'b1; req_write = 1'b1; req_bank = 2'd3; req_col = CW'(11);
                req_ap = 1'b1;
            end
            if (k <= 5) chk("R10", "ready", int'(req_ready), int'(k == 5));
            if (k == 6) begin
                req_valid = 1'b0; req_write = 1'b0;
                chk("R10", "wr ba", int'(cmd_ba), 3);
                chk("R10", "wr addr", int'(cmd_addr), 11);
                chk("R10", "drive at wr", int'(bus_drive), 0);
            end
            ecmd = (k == 0) ? C_RD : (k == 2 ? C_BST : (k == 6 ? C_WR : C_NOP));
            chk("R10", "cmd", decode(), ecmd);
        end

        // R10: write from idle is taken at once.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_bank = 2'd1; req_col = CW'(2); req_ap = 1'b0;
        chk("R10", "ready idle", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R10", "cmd idle wr", decode(), C_WR);

        // R1: reset in the middle of a burst.
        @(negedge clk);
        send_read(2, 4, 4, 0, 2);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cmd after rst", decode(), C_NOP);
        chk("R1", "drive after rst", int'(bus_drive), 0);
        chk("R1", "ready after rst", int'(req_ready), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule